// File: doc/BRIEF.md
# Receive Ring Writer

This block stores incoming frames into a circular ring of 256-byte pages in a local buffer memory. Software sets the first and last-plus-one page of the ring and a boundary page that marks where its reader has got to. The block keeps a current-page register that points at the page where the next frame will begin. Frame bytes arrive on a valid/ready byte stream. The first byte is flagged as start of frame. The last byte is flagged as end of frame and carries the CRC and alignment error flags. Each byte accepted into storage becomes one write on a single-cycle memory port.

Frame data is stored from offset 4 of the frame's first page. When a page fills, storage moves on to the next page, and the page after the last one in the ring is the ring's first page. After a good frame, the block writes a four-byte descriptor into offsets 0 to 3 of the first page. It then moves the current page past the frame and raises a one-cycle packet-received pulse. A rejected frame leaves the current page where it was, so its pages are reused. A frame that would link into the boundary page is abandoned, and a sticky overflow flag is raised.

Top module: `rxRingWriter`

## Requirements
- R1: Reset leaves memWe=0, rxReady=1, pktRcvd=0, overflow=0, curPage=0 and all ring registers at 0.
- R2: The start-of-frame byte is written at address {curPage, 8'd4}. Each later byte of the frame is written at the next offset of the same page.
- R3: After a byte is written at offset 255, the frame's next byte goes to offset 0 of the following page.
- R4: The page following page stop-1 is the start page. This applies both to linking within a frame and to the advance of the current page.
- R5: If the page following a full page equals the boundary register, the frame is abandoned and overflow goes to 1. Its remaining bytes are accepted without any write, no descriptor is written and curPage does not change.
- R6: Overflow stays at 1 until a write to the boundary register (regSel=2) clears it.
- R7: The last byte of a frame is accepted. If that frame is good, the four following cycles hold rxReady=0 and write addresses {first page, offset 0..3}. The data written in those cycles is, in order: 8'h01, the next-frame page, the frame length bits 7:0 and the frame length bits 15:8.
- R8: The next-frame page is the page after the last page holding frame data, with wrap. In the cycle after the fourth descriptor write, pktRcvd is 1 for exactly one cycle and curPage equals the next-frame page.
- R9: A frame is rejected if it ends with rxCrcErr or rxAlignErr set, or if it is shorter than 64 bytes. A rejected frame writes no descriptor, raises no pulse and leaves curPage unchanged, so the next frame starts on the same page.
- R10: While no frame is open, bytes without rxSof are accepted and cause no memory write.
- R11: A register write with regWe=1 loads regData into: start page (regSel=0), stop page (1), boundary (2) or current page (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Ring register write strobe |
| regSel | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| regData | input | PAGE_W | Register write data (page number) |
| rxValid | input | 1 | Byte stream valid |
| rxSof | input | 1 | Byte is the first of a frame |
| rxLast | input | 1 | Byte is the last of a frame |
| rxCrcErr | input | 1 | Frame CRC error, qualified by rxLast |
| rxAlignErr | input | 1 | Frame alignment error, qualified by rxLast |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Block accepts a byte this cycle |
| memAddr | output | PAGE_W+OFF_W | Buffer memory byte address {page, offset} |
| memData | output | 8 | Buffer memory write data |
| memWe | output | 1 | Buffer memory write strobe |
| pktRcvd | output | 1 | One-cycle pulse when a frame is committed |
| overflow | output | 1 | Sticky ring overflow flag |
| curPage | output | PAGE_W | Current page register |

## Verification
Four rules are checked by the assertions on every cycle:
- Any write made while rxReady is low lands at a descriptor offset below 4.
- The packet pulse lasts one cycle and directly follows the write at offset 3.
- The current page changes only through a commit or a software write.
- Overflow holds until the boundary register is written.

Other properties are shown only by the bench's scenarios, with a reference model compared on every clock. These are the exact address sequence across a page link and across the ring wrap, the contents of the descriptor bytes, and the rollback after CRC, alignment and runt rejects. The abort at the boundary page and the silent draining of the abandoned frame's tail are also covered there.

// File: rtl/rxRingPkg.sv
package rxRingPkg;
  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;
  localparam logic [7:0] STATUS_OK = 8'h01;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STOP  = 2'd1;
  localparam logic [1:0] SEL_BOUND = 2'd2;
  localparam logic [1:0] SEL_CUR   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_HDR
  } rxState_t;

  typedef struct packed {
    logic       startFrame;
    logic       storeByte;
    logic       abortFrame;
    logic       hdrWrite;
    logic [1:0] hdrIdx;
    logic       commit;
  } dpStrobe_t;
endpackage

// File: rtl/rxRingCtrl.sv
module rxRingCtrl
  import rxRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxLast,
  input  logic       rxCrcErr,
  input  logic       rxAlignErr,
  input  logic       linkBlocked,
  input  logic       tooShort,
  output logic       rxReady,
  output dpStrobe_t  strobe
);
  rxState_t   state, stateNext;
  logic [1:0] hdrCnt, hdrCntNext;
  logic       frameBad;

  assign frameBad = tooShort | rxCrcErr | rxAlignErr;
  assign rxReady  = (state != ST_HDR);

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    hdrCntNext = hdrCnt;
    unique case (state)
      ST_IDLE: begin
        if (rxValid && rxSof) begin
          strobe.startFrame = 1'b1;
          strobe.storeByte  = 1'b1;
          if (rxLast) stateNext = frameBad ? ST_IDLE : ST_HDR;
          else        stateNext = ST_RECV;
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          strobe.storeByte = 1'b1;
          if (linkBlocked) begin
            strobe.abortFrame = 1'b1;
            stateNext = rxLast ? ST_IDLE : ST_DROP;
          end else if (rxLast) begin
            stateNext = frameBad ? ST_IDLE : ST_HDR;
          end
        end
      end
      ST_DROP: begin
        if (rxValid && rxLast) stateNext = ST_IDLE;
      end
      ST_HDR: begin
        strobe.hdrWrite = 1'b1;
        strobe.hdrIdx   = hdrCnt;
        if (hdrCnt == 2'(HDR_BYTES - 1)) begin
          strobe.commit = 1'b1;
          hdrCntNext    = '0;
          stateNext     = ST_IDLE;
        end else begin
          hdrCntNext = hdrCnt + 2'd1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= '0;
    end else begin
      state  <= stateNext;
      hdrCnt <= hdrCntNext;
    end
  end
endmodule

// File: rtl/rxRingDatapath.sv
module rxRingDatapath
  import rxRingPkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int OFF_W    = 8,
  parameter int RUNT_MIN = 64,
  localparam int ADDR_W  = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [PAGE_W-1:0] regData,
  input  logic [7:0]        rxData,
  output logic              linkBlocked,
  output logic              tooShort,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              memWe,
  output logic [PAGE_W-1:0] curPage,
  output logic              overflow,
  output logic              pktRcvd
);
  logic [PAGE_W-1:0] startPg, stopPg, bndPg, curPg, firstPg, wrPage, nextPkt;
  logic [OFF_W-1:0]  wrOff;
  logic [LEN_W-1:0]  byteCnt, cntNext;

  function automatic logic [PAGE_W-1:0] incPage(input logic [PAGE_W-1:0] p);
    logic [PAGE_W-1:0] p1;
    p1 = p + 1'b1;
    return (p1 == stopPg) ? startPg : p1;
  endfunction

  assign cntNext     = strobe.startFrame ? LEN_W'(1) : byteCnt + 1'b1;
  assign tooShort    = cntNext < LEN_W'(RUNT_MIN);
  assign linkBlocked = !strobe.startFrame && (wrOff == '1) && (incPage(wrPage) == bndPg);
  assign nextPkt     = (wrOff == '0) ? wrPage : incPage(wrPage);

  always_comb begin
    memWe   = strobe.storeByte | strobe.hdrWrite;
    memAddr = {wrPage, wrOff};
    memData = rxData;
    if (strobe.hdrWrite) begin
      memAddr = {firstPg, OFF_W'(strobe.hdrIdx)};
      unique case (strobe.hdrIdx)
        2'd0:    memData = STATUS_OK;
        2'd1:    memData = 8'(nextPkt);
        2'd2:    memData = byteCnt[7:0];
        default: memData = byteCnt[15:8];
      endcase
    end else if (strobe.startFrame) begin
      memAddr = {curPg, OFF_W'(HDR_BYTES)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPg  <= '0;
      stopPg   <= '0;
      bndPg    <= '0;
      curPg    <= '0;
      firstPg  <= '0;
      wrPage   <= '0;
      wrOff    <= '0;
      byteCnt  <= '0;
      overflow <= 1'b0;
      pktRcvd  <= 1'b0;
    end else begin
      if (regWe) begin
        unique case (regSel)
          SEL_START: startPg <= regData;
          SEL_STOP:  stopPg  <= regData;
          SEL_BOUND: begin bndPg <= regData; overflow <= 1'b0; end
          default:   curPg   <= regData;
        endcase
      end
      if (strobe.storeByte) begin
        byteCnt <= cntNext;
        if (strobe.startFrame) begin
          firstPg <= curPg;
          wrPage  <= curPg;
          wrOff   <= OFF_W'(HDR_BYTES + 1);
        end else if (wrOff == '1) begin
          wrPage <= incPage(wrPage);
          wrOff  <= '0;
        end else begin
          wrOff <= wrOff + 1'b1;
        end
      end
      if (strobe.abortFrame) overflow <= 1'b1;
      if (strobe.commit)     curPg    <= nextPkt;
      pktRcvd <= strobe.commit;
    end
  end

  assign curPage = curPg;
endmodule

// File: rtl/rxRingWriter.sv
module rxRingWriter
  import rxRingPkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int OFF_W    = 8,
  parameter int RUNT_MIN = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic [1:0]                regSel,
  input  logic [PAGE_W-1:0]         regData,
  input  logic                      rxValid,
  input  logic                      rxSof,
  input  logic                      rxLast,
  input  logic                      rxCrcErr,
  input  logic                      rxAlignErr,
  input  logic [7:0]                rxData,
  output logic                      rxReady,
  output logic [PAGE_W+OFF_W-1:0]   memAddr,
  output logic [7:0]                memData,
  output logic                      memWe,
  output logic                      pktRcvd,
  output logic                      overflow,
  output logic [PAGE_W-1:0]         curPage
);
  dpStrobe_t strobe;
  logic      linkBlocked, tooShort;

  rxRingCtrl i_ctrl (
    .clk, .rstN, .rxValid, .rxSof, .rxLast, .rxCrcErr, .rxAlignErr,
    .linkBlocked, .tooShort, .rxReady, .strobe
  );

  rxRingDatapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .RUNT_MIN(RUNT_MIN)) i_dp (
    .clk, .rstN, .strobe, .regWe, .regSel, .regData, .rxData,
    .linkBlocked, .tooShort, .memAddr, .memData, .memWe,
    .curPage, .overflow, .pktRcvd
  );
endmodule

// File: rtl/rxRingWriter_chk.sv
module rxRingWriter_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWe,
  input logic [1:0]              regSel,
  input logic                    rxValid,
  input logic                    rxReady,
  input logic [PAGE_W+OFF_W-1:0] memAddr,
  input logic                    memWe,
  input logic                    pktRcvd,
  input logic                    overflow,
  input logic [PAGE_W-1:0]       curPage
);
  // R8
  pkt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktRcvd |=> !pktRcvd);

  // R8
  pkt_after_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktRcvd |-> $past(memWe) && ($past(memAddr[OFF_W-1:0]) == OFF_W'(3)));

  // R7
  hdr_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !rxReady) |-> (memAddr[OFF_W-1:0] < OFF_W'(4)));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(regWe && regSel == 2'd2)) |=> overflow);

  // R10
  we_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && rxReady) |-> rxValid);

  // R9
  cur_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curPage) |-> (pktRcvd || $past(regWe && regSel == 2'd3)));
endmodule

bind rxRingWriter rxRingWriter_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/test_rxRingWriter.sv
module test_rxRingWriter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, regWe, rxValid, rxSof, rxLast, rxCrcErr, rxAlignErr;
  logic [1:0]  regSel;
  logic [7:0]  regData, rxData, memData, curPage;
  logic [15:0] memAddr;
  logic        rxReady, memWe, pktRcvd, overflow;

  rxRingWriter i_rxRingWriter (.*);

  int checks = 0, fails = 0;
  int mSt, mCur, mStart, mStop, mBnd, mWr, mFirst, mCnt, mNext;
  bit mOvf, mPkt;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int incP(int p);
    int q = (p + 1) & 255;
    return (q == mStop) ? mStart : q;
  endfunction

  task automatic tick();
    int eWe, eAddr, eData, eRdy, idx, np;
    bit ab;
    #1;
    eRdy = (mSt <= 2); eWe = 0; eAddr = 0; eData = 0;
    if (mSt == 0 && rxValid && rxSof) begin eWe = 1; eAddr = mCur*256 + 4; eData = rxData; end
    else if (mSt == 1 && rxValid) begin eWe = 1; eAddr = mWr; eData = rxData; end
    else if (mSt >= 3) begin
      idx = mSt - 3; eWe = 1; eAddr = mFirst*256 + idx;
      eData = (idx == 0) ? 1 : (idx == 1) ? mNext : (idx == 2) ? (mCnt & 255) : (mCnt >> 8);
    end
    chk("R10 memWe", memWe, eWe);
    chk("R7 rxReady", rxReady, eRdy);
    if (eWe != 0) begin
      chk("R2/R3/R4/R7 memAddr", memAddr, eAddr);
      chk("R7 memData", memData, eData);
    end
    chk("R8 pktRcvd", pktRcvd, mPkt);
    chk("R5/R6 overflow", overflow, mOvf);
    chk("R9/R11 curPage", curPage, mCur);
    @(posedge clk);
    mPkt = 0; ab = 0;
    case (mSt)
      0: if (rxValid && rxSof) begin
           mFirst = mCur; mCnt = 1; mWr = mCur*256 + 5;
           mSt = rxLast ? 0 : 1;
         end
      1: if (rxValid) begin
           mCnt++;
           if ((mWr & 255) == 255) begin
             np = incP(mWr >> 8);
             if (np == mBnd) begin mOvf = 1; ab = 1; mSt = rxLast ? 0 : 2; end
             else mWr = np*256;
           end else mWr++;
           if (!ab && rxLast) begin
             if (rxCrcErr || rxAlignErr || mCnt < 64) mSt = 0;
             else begin
               mSt = 3;
               mNext = ((mWr & 255) == 0) ? (mWr >> 8) : incP(mWr >> 8);
             end
           end
         end
      2: if (rxValid && rxLast) mSt = 0;
      3, 4, 5: mSt++;
      default: begin mSt = 0; mCur = mNext; mPkt = 1; end
    endcase
    if (regWe) begin
      case (regSel)
        2'd0: mStart = regData;
        2'd1: mStop = regData;
        2'd2: begin mBnd = regData; mOvf = 0; end
        default: mCur = regData;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic regWr(int sel, int val);
    regWe = 1; regSel = 2'(sel); regData = 8'(val);
    tick();
    regWe = 0;
  endtask

  task automatic sendFrame(int len, bit crc, bit aln, int seed);
    for (int i = 0; i < len; i++) begin
      if (i % 9 == 5) begin rxValid = 0; tick(); end
      rxValid = 1; rxSof = (i == 0); rxLast = (i == len - 1);
      rxCrcErr = crc && (i == len - 1); rxAlignErr = aln && (i == len - 1);
      rxData = 8'(seed + i*3);
      tick();
    end
    rxValid = 0; rxSof = 0; rxLast = 0; rxCrcErr = 0; rxAlignErr = 0;
    repeat (6) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; regWe = 0; regSel = 0; regData = 0;
    rxValid = 0; rxSof = 0; rxLast = 0; rxCrcErr = 0; rxAlignErr = 0; rxData = 0;
    mSt = 0; mCur = 0; mStart = 0; mStop = 0; mBnd = 0; mWr = 0; mFirst = 0;
    mCnt = 0; mNext = 0; mOvf = 0; mPkt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 memWe", memWe, 0);
    chk("R1 rxReady", rxReady, 1);
    chk("R1 pktRcvd", pktRcvd, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 curPage", curPage, 0);
    @(negedge clk);

    // R11 ring setup
    regWr(0, 'h10); regWr(1, 'h14); regWr(2, 'h0F); regWr(3, 'h10);
    tick();
    chk("R11 curPage load", curPage, 'h10);

    sendFrame(100, 0, 0, 7);
    chk("R8 advance after single-page frame", curPage, 'h11);
    sendFrame(300, 0, 0, 40);
    chk("R3 advance after linked frame", curPage, 'h13);
    sendFrame(80, 1, 0, 90);
    chk("R9 crc reject keeps page", curPage, 'h13);
    sendFrame(63, 0, 0, 11);
    chk("R9 runt reject keeps page", curPage, 'h13);
    sendFrame(64, 0, 0, 200);
    chk("R4 wrap of current page", curPage, 'h10);

    // R10 stray bytes outside a frame
    rxValid = 1; rxData = 8'h55;
    repeat (5) tick();
    rxValid = 0;
    tick();
    chk("R10 stray bytes leave page", curPage, 'h10);

    regWr(2, 'h11);
    sendFrame(400, 0, 0, 3);
    chk("R5 overflow raised", overflow, 1);
    chk("R5 abort keeps page", curPage, 'h10);
    sendFrame(70, 0, 1, 9);
    chk("R9 align reject keeps page", curPage, 'h10);
    chk("R6 overflow sticky", overflow, 1);
    regWr(2, 'h12);
    tick();
    chk("R6 overflow cleared by boundary write", overflow, 0);

    regWr(3, 'h13);
    sendFrame(300, 0, 0, 77);
    chk("R4 wrap inside frame", curPage, 'h11);
    regWr(2, 'h0F);
    sendFrame(252, 0, 0, 5);
    chk("R3 frame ending at page end", curPage, 'h12);

    summary();
    $finish;
  end
endmodule